// File: doc/BRIEF.md
# Flash Program/Erase Suspend Controller

This block is the suspend and resume logic of a serial NOR flash model. It takes opcodes that an SPI front end has already decoded. It starts array operations of four kinds: sector erase, block erase, chip erase and page program. Each operation is modelled as a countdown timer. The block drives the write-in-progress flag (`wip`) and the suspended flag (`sus`). It also judges every command against a permission table, and the table depends on the current phase. That phase is one of: idle, running, suspend pending, suspended, or a page program nested inside an erase suspend.

A suspend stops the running timer. After a configurable latency of `SUS_LAT` cycles the block reports the operation as suspended. A later resume continues the timer from the count it stopped at. While an erase is suspended, the host may program a different page. While a program is suspended, neither programming nor erasing is allowed. Each command presented gets exactly one verdict, an accept pulse or a reject pulse. A rejected command changes no state.

Top module: `flash_suspend_ctrl`

## Requirements
- R1: A suspend opcode (75h or B0h) is accepted while a sector erase (20h), block erase (52h or D8h) or page program (02h) is running, provided the resume spacing of R8 has elapsed.
- R2: A suspend is rejected in these cases: when idle, when a suspend is pending or already in effect, and during a chip erase (C7h or 60h). A resume opcode is rejected when no operation is suspended.
- R3: After an accepted suspend, `wip`=1 and `sus`=0 hold for `SUS_LAT`-1 cycles. Exactly `SUS_LAT` cycles after the command, `wip`=0 and `sus`=1.
- R4: During an erase suspend, the block rejects 01h, 20h, 52h, D8h, C7h and 60h, and it accepts reads (03h, 0Bh). It also accepts a page program (02h). That program runs with `wip`=1 and `sus`=1 for `PP_CYC` cycles and then returns to `wip`=0 and `sus`=1. `activeAddr` keeps the address of the suspended erase.
- R5: During a program suspend, the block rejects 01h, 02h and all erase opcodes, and it accepts reads.
- R6: While suspended, the block accepts status reads (05h, 35h), 06h, 04h, ID reads (9Fh, 90h, ABh, 5Ah) and the resume opcode. It rejects deep power-down (B9h) and both suspend opcodes.
- R7: A resume (default 7Ah) sets `sus`=0 and `wip`=1. The operation then finishes after the cycles it had left, so the time spent running totals its full duration.
- R8: A suspend issued `SUS_LAT`-1 cycles after a resume is rejected. A suspend issued `SUS_LAT` cycles after the resume is accepted.
- R9: Asserting `pwrLoss` sets `wip`=0 and `sus`=0 on the next cycle and abandons the suspended operation, so a later resume is rejected.
- R10: Each command cycle without `pwrLoss` produces exactly one of `cmdAccept` or `cmdReject`, one cycle later. A rejected command leaves `wip`, `sus` and the suspended operation unchanged.
- R11: When idle, an erase or program opcode starts its operation with `wip`=1 for exactly its duration in cycles. While the operation runs unsuspended, status reads are accepted and other non-suspend commands are rejected.
- R12: During reset, `wip`, `sus`, `cmdAccept` and `cmdReject` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pwrLoss | input | 1 | Power-loss event; clears all operation state |
| cmdValid | input | 1 | A decoded command is present this cycle |
| cmdOp | input | 8 | Command opcode |
| cmdAddr | input | ADDR_W | Command address, captured when an operation starts |
| cmdAccept | output | 1 | One-cycle pulse: the command was accepted |
| cmdReject | output | 1 | One-cycle pulse: the command was refused |
| wip | output | 1 | Write in progress |
| sus | output | 1 | An operation is suspended |
| activeAddr | output | ADDR_W | Address of the current or suspended main operation |

## Verification
Every command is tried in every phase. In each phase, each command is checked for the verdict it draws. Running the same opcodes against an erase suspend and then against a program suspend separates the two permission sets; this matters most for 02h. Suspends are issued during sector, block, chip and program operations, and on both sides of the post-resume spacing. These cases separate the conditions for accepting a suspend from the latency counter. Completion is timed after a suspend and resume, and the count is compared with the uninterrupted run, which shows that the remaining count was kept intact.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

  typedef enum logic [2:0] {K_NONE, K_SE, K_BE, K_CE, K_PP} opKind_t;

  typedef enum logic [3:0] {
    C_READ, C_STAT, C_WRSR, C_SE, C_BE, C_CE, C_PP,
    C_SUSP, C_RES, C_MISC, C_DP, C_OTHER
  } cmdClass_t;

  typedef enum logic [2:0] {S_IDLE, S_RUN, S_HALTING, S_PARKED, S_NESTED} ctlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startMain;
    logic tickMain;
    logic startNest;
    logic tickNest;
    logic startLat;
    logic tickLat;
    logic armGap;
    logic wipeAll;
  } dpStrobe_t;

  function automatic cmdClass_t classify(input logic [7:0] op, input logic [7:0] resumeOp);
    if (op == resumeOp) return C_RES;
    case (op)
      8'h03, 8'h0B:                                    return C_READ;
      8'h05, 8'h35:                                    return C_STAT;
      8'h01:                                           return C_WRSR;
      8'h20:                                           return C_SE;
      8'h52, 8'hD8:                                    return C_BE;
      8'hC7, 8'h60:                                    return C_CE;
      8'h02:                                           return C_PP;
      8'h75, 8'hB0:                                    return C_SUSP;
      8'h06, 8'h04, 8'h9F, 8'h90, 8'hAB, 8'h5A, 8'hA3: return C_MISC;
      8'hB9:                                           return C_DP;
      default:                                         return C_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/fsc_data.sv
module fsc_data
  import fsc_pkg::*;
#(
  parameter int ADDR_W  = 20,
  parameter int SE_CYC  = 60,
  parameter int BE_CYC  = 90,
  parameter int CE_CYC  = 120,
  parameter int PP_CYC  = 24,
  parameter int SUS_LAT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  opKind_t           startKind,
  input  logic [ADDR_W-1:0] startAddr,
  output opKind_t           kind,
  output logic [ADDR_W-1:0] activeAddr,
  output logic              mainLast,
  output logic              nestLast,
  output logic              latLast,
  output logic              gapClear
);

  localparam int MAX_A   = (SE_CYC > BE_CYC) ? SE_CYC : BE_CYC;
  localparam int MAX_B   = (CE_CYC > PP_CYC) ? CE_CYC : PP_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CYC = (MAX_AB > SUS_LAT) ? MAX_AB : SUS_LAT;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] remain, nestCnt, latCnt, gapCnt, startDur;

  always_comb begin
    case (startKind)
      K_SE:    startDur = CNT_W'(SE_CYC);
      K_BE:    startDur = CNT_W'(BE_CYC);
      K_CE:    startDur = CNT_W'(CE_CYC);
      K_PP:    startDur = CNT_W'(PP_CYC);
      default: startDur = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kind       <= K_NONE;
      activeAddr <= '0;
      remain     <= '0;
      nestCnt    <= '0;
      latCnt     <= '0;
      gapCnt     <= '0;
    end else if (strb.wipeAll) begin
      kind       <= K_NONE;
      activeAddr <= '0;
      remain     <= '0;
      nestCnt    <= '0;
      latCnt     <= '0;
      gapCnt     <= '0;
    end else begin
      if (strb.startMain) begin
        kind       <= startKind;
        activeAddr <= startAddr;
        remain     <= startDur;
      end else if (strb.tickMain && remain != '0) begin
        remain <= remain - 1'b1;
      end
      if (strb.startNest)                       nestCnt <= CNT_W'(PP_CYC);
      else if (strb.tickNest && nestCnt != '0)  nestCnt <= nestCnt - 1'b1;
      if (strb.startLat)                        latCnt <= CNT_W'(SUS_LAT);
      else if (strb.tickLat && latCnt != '0)    latCnt <= latCnt - 1'b1;
      if (strb.armGap)                          gapCnt <= CNT_W'(SUS_LAT - 1);
      else if (gapCnt != '0)                    gapCnt <= gapCnt - 1'b1;
    end
  end

  assign mainLast = (remain == CNT_W'(1));
  assign nestLast = (nestCnt == CNT_W'(1));
  assign latLast  = (latCnt == CNT_W'(1));
  assign gapClear = (gapCnt == '0);

  // R8: a resume must close the suspend window for the next cycle
  a_r8_gap_armed: assert property (@(posedge clk) disable iff (!rstN)
    (strb.armGap && !strb.wipeAll) |=> !gapClear);

  // R7: the main count is frozen whenever the main operation is not ticking
  a_r7_remain_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.tickMain && !strb.startMain && !strb.wipeAll) |=> $stable(remain));

endmodule

// File: rtl/fsc_ctrl.sv
module fsc_ctrl
  import fsc_pkg::*;
#(
  parameter logic [7:0] RESUME_OP = 8'h7A
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrLoss,
  input  logic       cmdValid,
  input  logic [7:0] cmdOp,
  input  opKind_t    kind,
  input  logic       mainLast,
  input  logic       nestLast,
  input  logic       latLast,
  input  logic       gapClear,
  output dpStrobe_t  strb,
  output opKind_t    startKind,
  output logic       cmdAccept,
  output logic       cmdReject,
  output logic       wip,
  output logic       sus
);

  ctlState_t state, nxt;
  cmdClass_t cls;
  logic      accNow, rejNow;

  always_comb begin
    strb      = '0;
    nxt       = state;
    accNow    = 1'b0;
    rejNow    = 1'b0;
    cls       = classify(cmdOp, RESUME_OP);
    case (cls)
      C_SE:    startKind = K_SE;
      C_BE:    startKind = K_BE;
      C_CE:    startKind = K_CE;
      C_PP:    startKind = K_PP;
      default: startKind = K_NONE;
    endcase

    if (pwrLoss) begin
      strb.wipeAll = 1'b1;
      nxt          = S_IDLE;
    end else begin
      case (state)
        S_IDLE: begin
          if (cmdValid) begin
            if (startKind != K_NONE) begin
              accNow         = 1'b1;
              strb.startMain = 1'b1;
              nxt            = S_RUN;
            end else if (cls == C_SUSP || cls == C_RES || cls == C_OTHER) begin
              rejNow = 1'b1;
            end else begin
              accNow = 1'b1;
            end
          end
        end
        S_RUN: begin
          if (cmdValid && cls == C_SUSP && kind != K_CE && gapClear) begin
            accNow        = 1'b1;
            strb.startLat = 1'b1;
            nxt           = S_HALTING;
          end else begin
            if (cmdValid) begin
              if (cls == C_STAT) accNow = 1'b1;
              else               rejNow = 1'b1;
            end
            strb.tickMain = 1'b1;
            if (mainLast) nxt = S_IDLE;
          end
        end
        S_HALTING: begin
          if (cmdValid) begin
            if (cls == C_STAT) accNow = 1'b1;
            else               rejNow = 1'b1;
          end
          strb.tickLat = 1'b1;
          if (latLast) nxt = S_PARKED;
        end
        S_PARKED: begin
          if (cmdValid) begin
            case (cls)
              C_RES: begin
                accNow      = 1'b1;
                strb.armGap = 1'b1;
                nxt         = S_RUN;
              end
              C_PP: begin
                if (kind != K_PP) begin
                  accNow         = 1'b1;
                  strb.startNest = 1'b1;
                  nxt            = S_NESTED;
                end else begin
                  rejNow = 1'b1;
                end
              end
              C_READ, C_STAT, C_MISC: accNow = 1'b1;
              default:                rejNow = 1'b1;
            endcase
          end
        end
        S_NESTED: begin
          if (cmdValid) begin
            if (cls == C_STAT) accNow = 1'b1;
            else               rejNow = 1'b1;
          end
          strb.tickNest = 1'b1;
          if (nestLast) nxt = S_PARKED;
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      cmdAccept <= 1'b0;
      cmdReject <= 1'b0;
    end else begin
      state     <= nxt;
      cmdAccept <= accNow;
      cmdReject <= rejNow;
    end
  end

  assign wip = (state == S_RUN) || (state == S_HALTING) || (state == S_NESTED);
  assign sus = (state == S_PARKED) || (state == S_NESTED);

  a_r10_single_verdict: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdAccept && cmdReject));

  a_r10_verdict_follows: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !pwrLoss) |=> (cmdAccept || cmdReject));

  a_r10_parked_reject_holds: assert property (@(posedge clk) disable iff (!rstN)
    (cmdReject && $past(state) == S_PARKED) |-> state == S_PARKED);

  a_r9_power_clear: assert property (@(posedge clk) disable iff (!rstN)
    pwrLoss |=> (!wip && !sus));

  a_r2_chip_erase_holds: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && kind == K_CE) |=> state != S_HALTING);

  a_r8_spacing_guard: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_RUN && !gapClear) |=> state != S_HALTING);

  a_r3_sus_after_latency: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sus) |-> $past(state) == S_HALTING);

endmodule

// File: rtl/flash_suspend_ctrl.sv
module flash_suspend_ctrl
  import fsc_pkg::*;
#(
  parameter int         ADDR_W    = 20,
  parameter int         SE_CYC    = 60,
  parameter int         BE_CYC    = 90,
  parameter int         CE_CYC    = 120,
  parameter int         PP_CYC    = 24,
  parameter int         SUS_LAT   = 5,
  parameter logic [7:0] RESUME_OP = 8'h7A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pwrLoss,
  input  logic              cmdValid,
  input  logic [7:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              cmdAccept,
  output logic              cmdReject,
  output logic              wip,
  output logic              sus,
  output logic [ADDR_W-1:0] activeAddr
);

  dpStrobe_t strb;
  opKind_t   startKind, kind;
  logic      mainLast, nestLast, latLast, gapClear;

  fsc_ctrl #(.RESUME_OP(RESUME_OP)) i_ctrl (
    .clk(clk), .rstN(rstN), .pwrLoss(pwrLoss), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .kind(kind), .mainLast(mainLast), .nestLast(nestLast), .latLast(latLast),
    .gapClear(gapClear), .strb(strb), .startKind(startKind),
    .cmdAccept(cmdAccept), .cmdReject(cmdReject), .wip(wip), .sus(sus)
  );

  fsc_data #(
    .ADDR_W(ADDR_W), .SE_CYC(SE_CYC), .BE_CYC(BE_CYC), .CE_CYC(CE_CYC),
    .PP_CYC(PP_CYC), .SUS_LAT(SUS_LAT)
  ) i_data (
    .clk(clk), .rstN(rstN), .strb(strb), .startKind(startKind), .startAddr(cmdAddr),
    .kind(kind), .activeAddr(activeAddr), .mainLast(mainLast), .nestLast(nestLast),
    .latLast(latLast), .gapClear(gapClear)
  );

endmodule

// File: tb/test_flash_suspend_ctrl.sv
module test_flash_suspend_ctrl;

  localparam int ADDR_W  = 20;
  localparam int SE_CYC  = 60;
  localparam int BE_CYC  = 90;
  localparam int CE_CYC  = 120;
  localparam int PP_CYC  = 24;
  localparam int SUS_LAT = 5;

  logic clk = 1'b0;
  logic rstN, pwrLoss, cmdValid;
  logic [7:0] cmdOp;
  logic [ADDR_W-1:0] cmdAddr, activeAddr;
  logic cmdAccept, cmdReject, wip, sus;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit qAcc[$];
  string qTag[$];

  always #5 clk = ~clk;

  flash_suspend_ctrl #(
    .ADDR_W(ADDR_W), .SE_CYC(SE_CYC), .BE_CYC(BE_CYC), .CE_CYC(CE_CYC),
    .PP_CYC(PP_CYC), .SUS_LAT(SUS_LAT), .RESUME_OP(8'h7A)
  ) i_flash_suspend_ctrl (
    .clk(clk), .rstN(rstN), .pwrLoss(pwrLoss), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdAddr(cmdAddr), .cmdAccept(cmdAccept), .cmdReject(cmdReject),
    .wip(wip), .sus(sus), .activeAddr(activeAddr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver: queue the expected verdict, present the command for one edge
  task automatic sendCmd(input logic [7:0] op, input bit expAcc, input string tag,
                         input logic [ADDR_W-1:0] addr);
    qAcc.push_back(expAcc);
    qTag.push_back(tag);
    cmdValid = 1'b1;
    cmdOp    = op;
    cmdAddr  = addr;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic chkFlags(input string tag, input int expWip, input int expSus);
    chk({tag, " wip"}, int'(wip), expWip);
    chk({tag, " sus"}, int'(sus), expSus);
  endtask

  task automatic powerLoss();
    pwrLoss = 1'b1;
    @(negedge clk);
    pwrLoss = 1'b0;
  endtask

  // monitor: compare each verdict with the head of the queue
  always @(negedge clk) begin
    if (rstN && (cmdAccept || cmdReject)) begin
      checks++;
      if (qAcc.size() == 0) begin
        errors++;
        $display("FAIL R10: unexpected verdict actual acc=%0b rej=%0b expected none",
                 cmdAccept, cmdReject);
      end else begin
        bit e;
        string t;
        e = qAcc.pop_front();
        t = qTag.pop_front();
        if (cmdAccept !== e || cmdReject !== !e) begin
          errors++;
          $display("FAIL %s: actual acc=%0b rej=%0b expected acc=%0b", t, cmdAccept, cmdReject, e);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; pwrLoss = 1'b0; cmdValid = 1'b0; cmdOp = 8'h00; cmdAddr = '0;
    waitCyc(3);
    chkFlags("R12 reset", 0, 0);
    chk("R12 reset acc", int'(cmdAccept), 0);
    chk("R12 reset rej", int'(cmdReject), 0);
    rstN = 1'b1;
    waitCyc(1);

    // idle verdicts
    sendCmd(8'h05, 1, "R11 idle status", '0);
    sendCmd(8'h75, 0, "R2 idle suspend", '0);
    sendCmd(8'h7A, 0, "R2 idle resume", '0);
    sendCmd(8'h03, 1, "R11 idle read", '0);

    // uninterrupted page program, duration and running verdicts
    sendCmd(8'h02, 1, "R11 start pp", 20'h00100);
    sendCmd(8'h05, 1, "R11 status while busy", '0);
    sendCmd(8'h03, 0, "R11 read while busy", '0);
    waitCyc(PP_CYC - 3);
    chkFlags("R11 pp last cycle", 1, 0);
    waitCyc(1);
    chkFlags("R11 pp done", 0, 0);

    // chip erase cannot be suspended
    sendCmd(8'h60, 1, "R11 start ce", 20'h00000);
    sendCmd(8'h75, 0, "R2 ce suspend 75h", '0);
    sendCmd(8'hB0, 0, "R2 ce suspend B0h", '0);
    chkFlags("R2 ce still running", 1, 0);
    powerLoss();
    chkFlags("R9 ce abandoned", 0, 0);

    // sector erase, suspend, permission table, nested program, resume
    sendCmd(8'h20, 1, "R1 start se", 20'h0A000);
    waitCyc(5);
    sendCmd(8'h75, 1, "R1 suspend se", '0);
    waitCyc(SUS_LAT - 1);
    chkFlags("R3 before latency", 1, 0);
    waitCyc(1);
    chkFlags("R3 after latency", 0, 1);
    sendCmd(8'h01, 0, "R4 wrsr in erase suspend", '0);
    sendCmd(8'h20, 0, "R4 20h in erase suspend", '0);
    sendCmd(8'h52, 0, "R4 52h in erase suspend", '0);
    sendCmd(8'hD8, 0, "R4 D8h in erase suspend", '0);
    sendCmd(8'hC7, 0, "R4 C7h in erase suspend", '0);
    sendCmd(8'h60, 0, "R4 60h in erase suspend", '0);
    sendCmd(8'hB9, 0, "R6 deep power-down", '0);
    sendCmd(8'h75, 0, "R6 second suspend 75h", '0);
    sendCmd(8'hB0, 0, "R6 second suspend B0h", '0);
    chkFlags("R10 rejects keep state", 0, 1);
    sendCmd(8'h03, 1, "R4 read 03h", '0);
    sendCmd(8'h0B, 1, "R4 read 0Bh", '0);
    sendCmd(8'h05, 1, "R6 status 05h", '0);
    sendCmd(8'h35, 1, "R6 status 35h", '0);
    sendCmd(8'h06, 1, "R6 wren", '0);
    sendCmd(8'h04, 1, "R6 wrdi", '0);
    sendCmd(8'h9F, 1, "R6 id 9Fh", '0);
    sendCmd(8'h90, 1, "R6 id 90h", '0);
    sendCmd(8'hAB, 1, "R6 id ABh", '0);
    sendCmd(8'h5A, 1, "R6 sfdp 5Ah", '0);
    chk("R4 addr held", int'(activeAddr), 32'h0A000);
    sendCmd(8'h02, 1, "R4 nested pp", 20'h0F000);
    chkFlags("R4 nested running", 1, 1);
    sendCmd(8'h7A, 0, "R4 resume during nested pp", '0);
    waitCyc(PP_CYC - 2);
    chkFlags("R4 nested last cycle", 1, 1);
    waitCyc(1);
    chkFlags("R4 nested done", 0, 1);
    chk("R4 addr after nested", int'(activeAddr), 32'h0A000);
    sendCmd(8'h7A, 1, "R7 resume se", '0);
    chkFlags("R7 resumed", 1, 0);
    waitCyc(SE_CYC - 6);
    chkFlags("R7 se last cycle", 1, 0);
    waitCyc(1);
    chkFlags("R7 se done", 0, 0);

    // block erase, resume spacing, power loss while suspended
    sendCmd(8'hD8, 1, "R1 start be", 20'h20000);
    waitCyc(3);
    sendCmd(8'hB0, 1, "R1 suspend be B0h", '0);
    waitCyc(SUS_LAT);
    chkFlags("R3 be suspended", 0, 1);
    sendCmd(8'h7A, 1, "R7 resume be", '0);
    waitCyc(SUS_LAT - 2);
    sendCmd(8'h75, 0, "R8 suspend too soon", '0);
    sendCmd(8'h75, 1, "R8 suspend at spacing", '0);
    waitCyc(SUS_LAT);
    chkFlags("R8 suspended again", 0, 1);
    powerLoss();
    chkFlags("R9 power loss", 0, 0);
    sendCmd(8'h7A, 0, "R9 resume after power loss", '0);
    chkFlags("R9 stays idle", 0, 0);

    // program suspend permission table
    sendCmd(8'h02, 1, "R1 start pp2", 20'h00200);
    waitCyc(2);
    sendCmd(8'h75, 1, "R1 suspend pp", '0);
    waitCyc(SUS_LAT);
    chkFlags("R3 pp suspended", 0, 1);
    sendCmd(8'h02, 0, "R5 pp in program suspend", '0);
    sendCmd(8'h01, 0, "R5 wrsr in program suspend", '0);
    sendCmd(8'h20, 0, "R5 20h in program suspend", '0);
    sendCmd(8'hD8, 0, "R5 D8h in program suspend", '0);
    sendCmd(8'h03, 1, "R5 read in program suspend", '0);
    chkFlags("R10 program suspend kept", 0, 1);
    sendCmd(8'h7A, 1, "R7 resume pp", '0);
    waitCyc(PP_CYC - 3);
    chkFlags("R7 pp last cycle", 1, 0);
    waitCyc(1);
    chkFlags("R7 pp done", 0, 0);

    waitCyc(2);
    chk("R10 all verdicts seen", qAcc.size(), 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule